// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block supervises a small processor core. It sits idle after a hardware reset. Software starts it by writing a two-byte key to one service address on the core's internal register write path. The first key byte arms the sequence and the second one completes it. Once running, a counter advances on every machine-cycle tick. Software keeps the system alive by repeating the same two-byte key before the counter runs out.

When the counter runs out, the block drives a reset request of fixed length in oscillator clocks. It also switches itself off, so the core comes back up with the watchdog disabled. Software cannot stop the watchdog once it runs; only a hardware reset or its own expiry does that. Power-down freezes the count. A configuration input selects whether idle mode freezes the count or lets it go on.

Top module: `kwdt_top`

## Requirements
- R1: While `rst_n` is low, and after it is released, `wdt_on_o` and `wdt_rst_o` are 0.
- R2: A write of `KEY_A` (default 8'h1E) to `SVC_ADDR` (default 8'hA6) followed by a write of `KEY_B` (default 8'hE1) to the same address sets `wdt_on_o` on the clock edge that takes the second write. The count starts from zero.
- R3: A `KEY_B` write to `SVC_ADDR` has no effect unless the most recent write to `SVC_ADDR` was `KEY_A`. Any other data value written to `SVC_ADDR` cancels a pending `KEY_A`. Writes to other addresses leave the pending state unchanged.
- R4: A complete key sequence while the watchdog runs restarts the count from zero.
- R5: Expiry comes on the (2^CNT_W − 1)-th advancing tick after the last service. From the next clock, `wdt_rst_o` is high for exactly `PULSE_CLKS` clocks.
- R6: Expiry clears `wdt_on_o` and any pending first key byte, so after the pulse the watchdog stays off until a new full key sequence arrives.
- R7: While `pdown` is high, ticks do not advance the count.
- R8: While `idle` is high, ticks advance the count when `idle_hold` is 0 and do not advance it when `idle_hold` is 1.
- R9: No write other than a completed key sequence changes `wdt_on_o` while the watchdog runs.
- R10: A completed key sequence in the same cycle as the tick that would cause expiry wins: no pulse, and the count restarts.
- R11: Writes to `SVC_ADDR` are ignored while `wdt_rst_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Hardware reset, active low, asynchronous |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | DATA_W | Register write data |
| mc_tick | input | 1 | One-clock pulse per machine cycle |
| idle | input | 1 | Core is in idle mode |
| pdown | input | 1 | Core is in power-down mode |
| idle_hold | input | 1 | 1: freeze the count during idle |
| wdt_rst_o | output | 1 | Reset request pulse |
| wdt_on_o | output | 1 | Watchdog is running |

## Verification
The bench builds the block with `CNT_W` = 5 and `PULSE_CLKS` = 6, keeping the default key bytes and service address. With these values expiry needs only 31 advancing ticks, so one short run can reach several expiries. The run covers each freeze condition, expiry coinciding with a refresh, and key writes that arrive during the pulse. The whole reset pulse can be watched clock by clock against a behavioural model.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;

  // Count may move on this tick only if no low-power state holds it.
  function automatic logic may_advance(input logic idle, input logic pdown,
                                       input logic idle_hold);
    return !pdown && !(idle && idle_hold);
  endfunction

  // Width needed to hold a down-counter loaded with n.
  function automatic int down_width(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/kwdt_keyseq.sv
module kwdt_keyseq #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] SVC_ADDR = 8'hA6,
  parameter logic [DATA_W-1:0] KEY_A = 8'h1E,
  parameter logic [DATA_W-1:0] KEY_B = 8'hE1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              block_i,
  input  logic              clear_i,
  output logic              armed_o,
  output logic              svc_o
);
  logic hit;
  logic armed_q;

  assign hit     = wr_en && (wr_addr == SVC_ADDR) && !block_i;
  assign svc_o   = hit && (wr_data == KEY_B) && armed_q;
  assign armed_o = armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
    end else if (clear_i) begin
      armed_q <= 1'b0;
    end else if (hit) begin
      armed_q <= (wr_data == KEY_A);
    end
  end
endmodule

// File: rtl/kwdt_count.sv
module kwdt_count #(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             adv_i,
  input  logic             svc_i,
  output logic             on_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             bite_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'((1 << CNT_W) - 2);

  logic             on_q;
  logic [CNT_W-1:0] cnt_q;
  logic             step;

  assign step   = on_q && tick_i && adv_i && !svc_i;
  assign bite_o = step && (cnt_q == LAST);
  assign on_o   = on_q;
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_q  <= 1'b0;
      cnt_q <= '0;
    end else if (svc_i) begin
      on_q  <= 1'b1;
      cnt_q <= '0;
    end else if (bite_o) begin
      on_q  <= 1'b0;
      cnt_q <= '0;
    end else if (step) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/kwdt_pulse.sv
module kwdt_pulse #(
  parameter int PULSE_CLKS = 98
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire_i,
  output logic busy_o
);
  localparam int PW = kwdt_pkg::down_width(PULSE_CLKS);

  logic [PW-1:0] left_q;

  assign busy_o = (left_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
    end else if (fire_i) begin
      left_q <= PW'(PULSE_CLKS);
    end else if (busy_o) begin
      left_q <= left_q - 1'b1;
    end
  end
endmodule

// File: rtl/kwdt_top.sv
module kwdt_top #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int CNT_W = 14,
  parameter int PULSE_CLKS = 98,
  parameter logic [ADDR_W-1:0] SVC_ADDR = 8'hA6,
  parameter logic [DATA_W-1:0] KEY_A = 8'h1E,
  parameter logic [DATA_W-1:0] KEY_B = 8'hE1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              mc_tick,
  input  logic              idle,
  input  logic              pdown,
  input  logic              idle_hold,
  output logic              wdt_rst_o,
  output logic              wdt_on_o
);
  // Internal events, named for the checker.
  logic             svc_w;
  logic             armed_w;
  logic             bite_w;
  logic             adv_w;
  logic             busy_w;
  logic [CNT_W-1:0] cnt_w;

  assign adv_w = kwdt_pkg::may_advance(idle, pdown, idle_hold);

  kwdt_keyseq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SVC_ADDR(SVC_ADDR),
    .KEY_A(KEY_A), .KEY_B(KEY_B)
  ) keyseq_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .block_i(busy_w), .clear_i(bite_w),
    .armed_o(armed_w), .svc_o(svc_w)
  );

  kwdt_count #(.CNT_W(CNT_W)) count_i (
    .clk(clk), .rst_n(rst_n), .tick_i(mc_tick), .adv_i(adv_w),
    .svc_i(svc_w), .on_o(wdt_on_o), .cnt_o(cnt_w), .bite_o(bite_w)
  );

  kwdt_pulse #(.PULSE_CLKS(PULSE_CLKS)) pulse_i (
    .clk(clk), .rst_n(rst_n), .fire_i(bite_w), .busy_o(busy_w)
  );

  assign wdt_rst_o = busy_w;
endmodule

// File: rtl/kwdt_checker.sv
module kwdt_checker #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int CNT_W = 14,
  parameter int PULSE_CLKS = 98,
  parameter logic [ADDR_W-1:0] SVC_ADDR = 8'hA6,
  parameter logic [DATA_W-1:0] KEY_B = 8'hE1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              mc_tick,
  input logic              idle,
  input logic              pdown,
  input logic              idle_hold,
  input logic              svc,
  input logic              armed,
  input logic              bite,
  input logic [CNT_W-1:0]  cnt,
  input logic              rst_out,
  input logic              on
);
  int run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_len <= 0;
    else        run_len <= rst_out ? run_len + 1 : 0;
  end

  a_r1_quiet_in_reset: assert property (@(posedge clk)
    !rst_n |-> (!on && !rst_out));

  a_r2_key_starts: assert property (@(posedge clk) disable iff (!rst_n)
    svc |=> (on && cnt == '0));

  a_r3_lone_second_key: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == SVC_ADDR && wr_data == KEY_B && !armed && !on)
      |=> !on);

  a_r5_pulse_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_out) |-> (run_len == PULSE_CLKS));

  a_r6_off_after_bite: assert property (@(posedge clk) disable iff (!rst_n)
    bite |=> (!on && !armed && rst_out));

  a_r7_pdown_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (on && pdown && !svc) |=> $stable(cnt));

  a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (on && idle && idle_hold && !svc) |=> $stable(cnt));

  a_r8_idle_runs: assert property (@(posedge clk) disable iff (!rst_n)
    (on && idle && !idle_hold && !pdown && mc_tick && !svc && !bite)
      |=> (cnt == $past(cnt) + 1'b1));

  a_r10_service_wins: assert property (@(posedge clk) disable iff (!rst_n)
    svc |-> !bite);

  a_r11_no_key_in_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rst_out |-> !svc);
endmodule

bind kwdt_top kwdt_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
  .PULSE_CLKS(PULSE_CLKS), .SVC_ADDR(SVC_ADDR), .KEY_B(KEY_B)
) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .mc_tick(mc_tick), .idle(idle), .pdown(pdown),
  .idle_hold(idle_hold), .svc(svc_w), .armed(armed_w), .bite(bite_w),
  .cnt(cnt_w), .rst_out(wdt_rst_o), .on(wdt_on_o)
);

// File: tb/kwdt_top_tb_top.sv
module kwdt_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 5;
  localparam int PULSE_CLKS = 6;
  localparam int LIMIT = (1 << CNT_W) - 1;   // 31 advancing ticks
  localparam int SVC = 8'hA6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       mc_tick = 1'b0;
  logic       idle = 1'b0;
  logic       pdown = 1'b0;
  logic       idle_hold = 1'b0;
  logic       wdt_rst_o;
  logic       wdt_on_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  // Reference model state.
  int m_on = 0, m_cnt = 0, m_armed = 0, m_pulse = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  kwdt_top #(.CNT_W(CNT_W), .PULSE_CLKS(PULSE_CLKS)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .mc_tick(mc_tick), .idle(idle), .pdown(pdown),
    .idle_hold(idle_hold), .wdt_rst_o(wdt_rst_o), .wdt_on_o(wdt_on_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural model, evaluated on each rising edge.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_on = 0; m_cnt = 0; m_armed = 0; m_pulse = 0;
    end else begin
      automatic bit busy = (m_pulse > 0);
      automatic bit hit  = wr_en && (wr_addr == SVC) && !busy;
      automatic bit svc  = hit && (wr_data == 8'hE1) && (m_armed != 0);
      automatic bit bite = 1'b0;
      if (busy) m_pulse = m_pulse - 1;
      if (svc) begin
        m_on = 1; m_cnt = 0;
      end else if (m_on != 0 && mc_tick && !pdown && !(idle && idle_hold)) begin
        if (m_cnt + 1 == LIMIT) begin
          bite = 1'b1; m_on = 0; m_cnt = 0; m_pulse = PULSE_CLKS;
        end else m_cnt = m_cnt + 1;
      end
      if (bite) m_armed = 0;
      else if (hit) m_armed = (wr_data == 8'h1E);
    end
  end

  // Per-clock comparison just after the edge.
  always @(posedge clk) begin
    #1;
    if (!done) begin
      check(wdt_rst_o == (m_pulse > 0), "R5 pulse vs model", wdt_rst_o, m_pulse > 0);
      check(wdt_on_o == (m_on != 0), "R2 enable vs model", wdt_on_o, m_on);
    end
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    mc_tick = 1'b1;
    repeat (n) @(negedge clk);
    mc_tick = 1'b0;
  endtask

  task automatic clocks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_state(input bit on, input bit rs, input string req);
    check(wdt_on_o == on, req, wdt_on_o, on);
    check(wdt_rst_o == rs, req, wdt_rst_o, rs);
  endtask

  task automatic enable();
    wr(8'hA6, 8'h1E);
    wr(8'hA6, 8'hE1);
  endtask

  // Watchdog of the bench itself.
  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog timeout actual=%0d expected<=20000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    expect_state(0, 0, "R1 during reset");
    clocks(2);
    rst_n = 1'b1;
    clocks(2);
    expect_state(0, 0, "R1 after reset");

    // R3: lone second key, cancelled first key, unrelated address.
    wr(8'hA6, 8'hE1);
    expect_state(0, 0, "R3 lone E1");
    wr(8'hA6, 8'h1E); wr(8'hA6, 8'h55); wr(8'hA6, 8'hE1);
    expect_state(0, 0, "R3 cancelled key");
    wr(8'hA6, 8'h1E); wr(8'h10, 8'hE1); wr(8'hA6, 8'hE1);
    expect_state(1, 0, "R3 R2 other address keeps pending key");

    // R9 and R4.
    ticks(20);
    wr(8'hA6, 8'h00); wr(8'h10, 8'h00);
    expect_state(1, 0, "R9 stray writes do not stop");
    enable();
    ticks(LIMIT - 1);
    expect_state(1, 0, "R4 refresh restarted count");
    ticks(1);
    expect_state(0, 1, "R5 R6 expiry");

    // R11: keys during pulse ignored.
    enable();
    clocks(PULSE_CLKS - 3);
    check(wdt_rst_o == 1'b1, "R5 pulse last clock", wdt_rst_o, 1);
    clocks(1);
    expect_state(0, 0, "R11 R5 pulse over, keys ignored");
    wr(8'hA6, 8'hE1);
    expect_state(0, 0, "R6 pending key cleared");

    // R7: power-down freezes.
    enable();
    pdown = 1'b1; ticks(100); pdown = 1'b0;
    expect_state(1, 0, "R7 frozen in power-down");
    ticks(LIMIT - 1);
    expect_state(1, 0, "R7 count resumed from zero");
    ticks(1);
    expect_state(0, 1, "R7 expiry after resume");
    clocks(PULSE_CLKS + 1);

    // R8: idle behaviour chosen by idle_hold.
    enable();
    idle = 1'b1; idle_hold = 1'b1; ticks(100);
    expect_state(1, 0, "R8 idle hold freezes");
    idle_hold = 1'b0; ticks(LIMIT - 1);
    expect_state(1, 0, "R8 idle counting");
    ticks(1);
    expect_state(0, 1, "R8 idle expiry");
    idle = 1'b0;
    clocks(PULSE_CLKS + 1);

    // R10: service on the expiring tick.
    enable();
    ticks(LIMIT - 1);
    wr(8'hA6, 8'h1E);
    mc_tick = 1'b1; wr(8'hA6, 8'hE1); mc_tick = 1'b0;
    expect_state(1, 0, "R10 service wins over expiry");
    ticks(LIMIT - 1);
    expect_state(1, 0, "R10 count restarted");
    ticks(1);
    expect_state(0, 1, "R10 later expiry");
    clocks(PULSE_CLKS + 1);

    // R1: hardware reset stops a running watchdog.
    enable();
    ticks(5);
    rst_n = 1'b0;
    clocks(1);
    expect_state(0, 0, "R1 reset while running");
    rst_n = 1'b1;
    clocks(2);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule